// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two bidirectional data buses, A and B, each `DATA_W` bits wide. Each direction owns a storage register with its own load strobe. The A-to-B register captures bus A, and the B-to-A register captures bus B. A per-direction source select chooses what the receiving bus gets: the live value on the opposite bus, or the stored register value. Because of this, data can be stored while both buses are isolated, and it can be replayed onto a bus later.

An active-low output enable and a direction input decide which single bus, if any, is driven. A parameter fixes whether the driven data is true or complemented. Each pad is modelled as three signals: an input, an output and an output enable. The load strobes are sampled in the system-clock domain, and a register loads on a sampled rising transition of its strobe.

Top module: `regbus_xcvr`

## Requirements
- R1: An asynchronous active-low reset `rst_n` clears both storage registers to zero. The pad enables `a_oe` and `b_oe` are not changed by reset.
- R2: The A-to-B register loads `a_in` at a `clk` rising edge where `cap_ab` is sampled high after being sampled low at the previous edge. The first high sample after reset counts as a rise. At every other edge the register keeps its value.
- R3: The B-to-A register loads `b_in` on a sampled rising transition of `cap_ba`, following the same rule as R2. At every other edge it keeps its value.
- R4: With `oe_n` high (isolation), `a_oe` and `b_oe` are both 0. Both registers still load as in R2 and R3.
- R5: With `oe_n` low, `dir`=1 gives `b_oe`=1 and `a_oe`=0, and `dir`=0 gives `a_oe`=1 and `b_oe`=0. `a_oe` and `b_oe` are never both 1.
- R6: When bus B is driven, `sel_ab`=0 gives `b_out` the live `a_in` in the same cycle. `sel_ab`=1 gives `b_out` the A-to-B register.
- R7: When bus A is driven, `sel_ba`=0 gives `a_out` the live `b_in` in the same cycle. `sel_ba`=1 gives `a_out` the B-to-A register.
- R8: With `INVERT`=1 the driven data is the bitwise complement of the selected value. With `INVERT`=0 it is unchanged.
- R9: A bus whose output enable is 0 has its output held at all zeros, so that the other bus's input has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_ab | input | 1 | Load strobe for the A-to-B register (rising transition) |
| cap_ba | input | 1 | Load strobe for the B-to-A register (rising transition) |
| sel_ab | input | 1 | Bus B source: 0 live A, 1 stored |
| sel_ba | input | 1 | Bus A source: 0 live B, 1 stored |
| oe_n | input | 1 | Output enable, active low |
| dir | input | 1 | 1 drives bus B, 0 drives bus A |
| a_in | input | DATA_W | Value seen on bus A pads |
| a_out | output | DATA_W | Value driven on bus A |
| a_oe | output | 1 | Bus A output enable |
| b_in | input | DATA_W | Value seen on bus B pads |
| b_out | output | DATA_W | Value driven on bus B |
| b_oe | output | 1 | Bus B output enable |

## Verification
Suppose a storage register misses a load, loads twice, or keeps a stale value. The error appears on the receiving bus in the first cycle that drives that bus with the stored source selected. This can be many cycles after the faulty edge, because storing while isolated is legal.

The bench therefore sweeps every combination of enable, direction and source select against changing data and strobe patterns. Any register error reaches a compare within a few cycles. Enable or inversion faults are visible combinationally in the same cycle.

// File: rtl/regbus_xcvr_pkg.sv
package regbus_xcvr_pkg;
  typedef struct packed {
    logic drive_a;
    logic drive_b;
  } drive_t;

  function automatic drive_t decode_drive(input logic oe_n, input logic dir);
    drive_t d;
    d.drive_a = ~oe_n & ~dir;
    d.drive_b = ~oe_n & dir;
    return d;
  endfunction
endpackage

// File: rtl/strobe_rise.sv
module strobe_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = lvl;
    rise   = lvl & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R2
endmodule

// File: rtl/hold_reg.sv
module hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (ld) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (q == $past(d))); // R2
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(q)); // R3
endmodule

// File: rtl/bus_drive.sv
module bus_drive #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic         en,
  input  logic         use_stored,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] out
);
  logic [W-1:0] picked;
  logic [W-1:0] shaped;

  always_comb picked = use_stored ? stored : live;

  generate
    if (INVERT) begin : g_inv
      always_comb shaped = ~picked;
    end else begin : g_true
      always_comb shaped = picked;
    end
  endgenerate

  always_comb out = en ? shaped : '0;
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
  import regbus_xcvr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_ab,
  input  logic              cap_ba,
  input  logic              sel_ab,
  input  logic              sel_ba,
  input  logic              oe_n,
  input  logic              dir,
  input  logic [DATA_W-1:0] a_in,
  output logic [DATA_W-1:0] a_out,
  output logic              a_oe,
  input  logic [DATA_W-1:0] b_in,
  output logic [DATA_W-1:0] b_out,
  output logic              b_oe
);
  localparam int W = DATA_W;

  drive_t       drv;
  logic         ld_ab, ld_ba;
  logic [W-1:0] st_ab, st_ba;

  always_comb begin
    drv  = decode_drive(oe_n, dir);
    a_oe = drv.drive_a;
    b_oe = drv.drive_b;
  end

  strobe_rise u_rise_ab (.clk(clk), .rst_n(rst_n), .lvl(cap_ab), .rise(ld_ab));
  strobe_rise u_rise_ba (.clk(clk), .rst_n(rst_n), .lvl(cap_ba), .rise(ld_ba));

  hold_reg #(.W(W)) u_reg_ab (.clk(clk), .rst_n(rst_n), .ld(ld_ab), .d(a_in), .q(st_ab));
  hold_reg #(.W(W)) u_reg_ba (.clk(clk), .rst_n(rst_n), .ld(ld_ba), .d(b_in), .q(st_ba));

  bus_drive #(.W(W), .INVERT(INVERT)) u_drv_b (
    .en(b_oe), .use_stored(sel_ab), .live(a_in), .stored(st_ab), .out(b_out));
  bus_drive #(.W(W), .INVERT(INVERT)) u_drv_a (
    .en(a_oe), .use_stored(sel_ba), .live(b_in), .stored(st_ba), .out(a_out));

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_oe && b_oe)); // R5
  AST_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (a_out == '0 && b_out == '0)); // R4
endmodule

// File: tb/regbus_xcvr_test.sv
module regbus_xcvr_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cap_ab = 0, cap_ba = 0, sel_ab = 0, sel_ba = 0, oe_n = 1, dir = 0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out0, b_out0, a_out1, b_out1;
  logic a_oe0, b_oe0, a_oe1, b_oe1;

  int n_chk = 0, n_bad = 0;
  logic [W-1:0] m_ab = '0, m_ba = '0;
  logic p_ab = 0, p_ba = 0;

  always #10 clk = ~clk;

  regbus_xcvr #(.DATA_W(W), .INVERT(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .cap_ab(cap_ab), .cap_ba(cap_ba),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .oe_n(oe_n), .dir(dir),
    .a_in(a_in), .a_out(a_out0), .a_oe(a_oe0),
    .b_in(b_in), .b_out(b_out0), .b_oe(b_oe0));

  regbus_xcvr #(.DATA_W(W), .INVERT(1'b1)) uut_inv (
    .clk(clk), .rst_n(rst_n), .cap_ab(cap_ab), .cap_ba(cap_ba),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .oe_n(oe_n), .dir(dir),
    .a_in(a_in), .a_out(a_out1), .a_oe(a_oe1),
    .b_in(b_in), .b_out(b_out1), .b_oe(b_oe1));

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all();
    logic ea, eb;
    logic [W-1:0] vb, va;
    ea = !oe_n && !dir;
    eb = !oe_n && dir;
    vb = sel_ab ? m_ab : a_in;
    va = sel_ba ? m_ba : b_in;
    chk("R4/R5 oe", {6'b0, a_oe0, b_oe0}, {6'b0, ea, eb});
    chk("R4/R5 oe inv", {6'b0, a_oe1, b_oe1}, {6'b0, ea, eb});
    chk("R6/R9 b_out", b_out0, eb ? vb : '0);
    chk("R7/R9 a_out", a_out0, ea ? va : '0);
    chk("R8 b_out inv", b_out1, eb ? ~vb : '0);
    chk("R8 a_out inv", a_out1, ea ? ~va : '0);
  endtask

  task automatic step();
    @(posedge clk);
    if (cap_ab && !p_ab) m_ab = a_in; // R2
    if (cap_ba && !p_ba) m_ba = b_in; // R3
    p_ab = cap_ab;
    p_ba = cap_ba;
  endtask

  initial begin
    #200000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1 reset state: stored paths read zero
    #15;
    sel_ab = 1; sel_ba = 1; oe_n = 0; dir = 1; a_in = 8'h5A; b_in = 8'hA5;
    #1; check_all();
    dir = 0; #1; check_all();
    chk("R1 stored b", b_out0, 8'h00);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < 1200; i++) begin
      @(negedge clk);
      a_in   = W'(i * 37 + 3);
      b_in   = W'(~(i * 11) ^ (i >> 3));
      cap_ab = (i % 3 == 0) || (i % 7 == 2);
      cap_ba = (i % 5 == 1) || (i % 4 == 3);
      {oe_n, dir, sel_ab, sel_ba} = 4'(i >> 1);
      #5; check_all();
      step();
    end

    // R1: asynchronous reset mid-run clears stored values, enables unchanged
    @(negedge clk);
    cap_ab = 0; cap_ba = 0; sel_ab = 1; sel_ba = 1; oe_n = 0; dir = 1;
    #2 rst_n = 0;
    m_ab = '0; m_ba = '0; p_ab = 0; p_ba = 0;
    #2; check_all();
    chk("R1 b_oe kept", {7'b0, b_oe0}, 8'h01);
    dir = 0; #1; check_all();
    chk("R1 stored a", a_out0, 8'h00);
    @(negedge clk); rst_n = 1;

    // R4: store while isolated, replay later (R2, R3)
    @(negedge clk); oe_n = 1; a_in = 8'hC3; b_in = 8'h3C; cap_ab = 1; cap_ba = 1;
    #5; check_all(); step();
    @(negedge clk); cap_ab = 0; cap_ba = 0; a_in = 8'h00; b_in = 8'hFF;
    #5; check_all(); step();
    @(negedge clk); oe_n = 0; dir = 1; #5; check_all();
    chk("R2 replay", b_out0, 8'hC3);
    dir = 0; #1; check_all();
    chk("R3 replay", a_out0, 8'h3C);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule